// File: doc/BRIEF.md
# Five-Stage Pipelined Mini-Processor Core

This block is a small in-order processor core with five pipeline stages: fetch, decode, execute, memory and writeback. It executes a compact subset of a 64-bit teaching instruction set: no-op, halt, move of an immediate into a register, register-to-register move, four ALU operations and conditional moves. Instruction bytes come from a byte-addressed instruction memory read port that returns ten bytes starting at the fetch address. Fifteen 64-bit architectural registers live inside the core and can be read through a debug read port.

Every read-after-write dependency is resolved by forwarding from execute, memory and writeback into decode, so the pipeline never stalls for data. When fetch sees a halt or an undefined encoding, it stops advancing and keeps refetching the same address. The status of that instruction then moves through the remaining pipeline registers. When it reaches writeback, it is shown on the status output, `done` rises and the whole core freezes. The memory stage carries its pipeline register but performs no data access.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted and right after it, status is 1 (running), done is 0, the fetch address is 0, all registers read 0, and the flags are Z=1, S=0, O=0.
- R2: Encodings and lengths are as follows. Byte 0x00 is halt and 0x10 is no-op, each 1 byte. 0x2F is a conditional move with fn F in 0..6 and is 2 bytes. 0x30 is an immediate move, followed by a byte 0xF/rB and an 8-byte little-endian immediate, 10 bytes in all. 0x6F is an ALU op with fn 0..3 and is 2 bytes. The register byte holds rA in the high nibble and rB in the low nibble. While running, the fetch address advances by the length of the fetched instruction.
- R3: Halt (0x00) ends the run with status 2. Counting N as the number of instructions fetched up to and including that halt, done rises after exactly N+3 rising clock edges following reset release. The fetch address never passes the halt.
- R4: Any other leading byte is an invalid instruction. This includes op 2 with fn>6, op 6 with fn>3, and ops 0, 1 or 3 with a nonzero low nibble. An invalid instruction ends the run with status 4 and the same N+3 timing, and neither it nor any later byte changes a register.
- R5: A source operand always receives the value of the newest older instruction that writes that register, even when the producer is directly ahead of the consumer, with no added cycles.
- R6: ALU op fn 0 computes rB=rB+rA, fn 1 computes rB=rB-rA, fn 2 computes rB=rB&rA and fn 3 computes rB=rB^rA.
- R7: Only ALU ops update the flags. Z is set when the result is zero and S is the result's top bit. O is signed overflow for add and sub and 0 for and/xor.
- R8: A conditional move copies rA to rB when its condition holds. The conditions by fn are: 0 always, 1 (S^O)|Z, 2 S^O, 3 Z, 4 !Z, 5 !(S^O), 6 !(S^O)&!Z.
- R9: A conditional move whose condition is false writes no register, and no later instruction receives a forwarded value from it.
- R10: Register code 0xF means none. An immediate move with rB=0xF changes no register.
- R11: Once done is high, status, fetch address, registers and done stay unchanged until reset.
- R12: rf_val combinationally shows register rf_sel for codes 0..14 and reads 0 for code 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | AW (16) | Fetch byte address |
| imem_bytes | input | 80 | Ten instruction bytes from imem_addr, lowest byte in bits 7:0 |
| rf_sel | input | 4 | Debug register select |
| rf_val | output | 64 | Debug register value |
| status | output | 3 | 1 running, 2 halted, 4 invalid instruction |
| done | output | 1 | High once a non-running status reaches writeback |

## Verification
The bench targets back-to-back dependent chains, where a core missing one forwarding path, or giving an older producer priority, leaves a stale register value. It also runs conditional moves under every condition code after add overflow, sign and zero results. A core that forwards from a discarded move, or decodes a condition wrongly, leaves a wrong destination value. Halt and invalid-opcode programs check the exact cycle count and the last fetch address. A core that lets fetch run on, or that drops a pipeline stage, reports early or late or fetches past the halt. An immediate move to register code 15 and an invalid move function code check that nothing is written where nothing should be.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;
    localparam int XLEN        = 64;
    localparam int NREG        = 15;
    localparam int FETCH_BYTES = 10;
    localparam int RIDW        = 4;

    typedef logic [RIDW-1:0] reg_id_t;
    localparam reg_id_t RNONE = 4'hF;

    typedef enum logic [2:0] {ST_AOK = 3'd1, ST_HLT = 3'd2, ST_INS = 3'd4} stat_e;

    localparam logic [3:0] OP_HALT = 4'h0;
    localparam logic [3:0] OP_NOP  = 4'h1;
    localparam logic [3:0] OP_MOV  = 4'h2;
    localparam logic [3:0] OP_IMM  = 4'h3;
    localparam logic [3:0] OP_ALU  = 4'h6;

    typedef struct packed { logic z; logic s; logic o; } flags_t;

    typedef struct packed {
        stat_e stat; logic [3:0] op; logic [3:0] fn;
        reg_id_t ra; reg_id_t rb; logic [XLEN-1:0] imm;
    } dec_t;

    typedef struct packed {
        stat_e stat; logic [3:0] op; logic [3:0] fn;
        logic [XLEN-1:0] va; logic [XLEN-1:0] vb; logic [XLEN-1:0] imm;
        reg_id_t dst;
    } exe_t;

    typedef struct packed {
        stat_e stat; logic cnd; logic [XLEN-1:0] val; reg_id_t dst;
    } mem_t;

    typedef struct packed {
        stat_e stat; logic [XLEN-1:0] val; reg_id_t dst;
    } wb_t;

    typedef struct packed { dec_t d; exe_t e; mem_t m; wb_t w; flags_t cc; } pipe_t;

    localparam pipe_t PIPE_RESET = '{
        d:  '{stat: ST_AOK, op: OP_NOP, fn: '0, ra: RNONE, rb: RNONE, imm: '0},
        e:  '{stat: ST_AOK, op: OP_NOP, fn: '0, va: '0, vb: '0, imm: '0, dst: RNONE},
        m:  '{stat: ST_AOK, cnd: 1'b0, val: '0, dst: RNONE},
        w:  '{stat: ST_AOK, val: '0, dst: RNONE},
        cc: '{z: 1'b1, s: 1'b0, o: 1'b0}
    };
endpackage

// File: rtl/pipe5_rf.sv
`timescale 1ns/1ps
module pipe5_rf import pipe5_pkg::*; #(
    parameter int W = XLEN,
    parameter int N = NREG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  reg_id_t       wa,
    input  logic [W-1:0]  wd,
    input  reg_id_t       ra_a,
    input  reg_id_t       ra_b,
    input  reg_id_t       ra_x,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_x
);
    logic [W-1:0] regs_q [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        regs_q[i] <= '0;
            else if (we && wa == RIDW'(i))     regs_q[i] <= wd;
        end
    end

    assign rd_a = (ra_a < RIDW'(N)) ? regs_q[ra_a] : '0;
    assign rd_b = (ra_b < RIDW'(N)) ? regs_q[ra_b] : '0;
    assign rd_x = (ra_x < RIDW'(N)) ? regs_q[ra_x] : '0;
endmodule

// File: rtl/pipe5_fwd.sv
`timescale 1ns/1ps
module pipe5_fwd import pipe5_pkg::*; #(
    parameter int W = XLEN
) (
    input  reg_id_t      src,
    input  reg_id_t      e_dst,
    input  logic [W-1:0] e_val,
    input  reg_id_t      m_dst,
    input  logic [W-1:0] m_val,
    input  reg_id_t      w_dst,
    input  logic [W-1:0] w_val,
    input  logic [W-1:0] rf_val,
    output logic [W-1:0] val
);
    always_comb begin
        if (src == RNONE)      val = '0;
        else if (src == e_dst) val = e_val;
        else if (src == m_dst) val = m_val;
        else if (src == w_dst) val = w_val;
        else                   val = rf_val;
    end
endmodule

// File: rtl/pipe5_alu.sv
`timescale 1ns/1ps
module pipe5_alu import pipe5_pkg::*; #(
    parameter int W = XLEN
) (
    input  logic [3:0]   fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output flags_t       fl
);
    always_comb begin
        fl.o = 1'b0;
        case (fn)
            4'd0: begin
                res  = b + a;
                fl.o = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
            end
            4'd1: begin
                res  = b - a;
                fl.o = (a[W-1] != b[W-1]) && (res[W-1] != b[W-1]);
            end
            4'd2:    res = b & a;
            4'd3:    res = b ^ a;
            default: res = b + a;
        endcase
        fl.z = (res == '0);
        fl.s = res[W-1];
    end
endmodule

module pipe5_cond import pipe5_pkg::*; (
    input  logic [3:0] fn,
    input  flags_t     fl,
    output logic       ok
);
    logic lt;
    assign lt = fl.s ^ fl.o;
    always_comb begin
        case (fn)
            4'd0:    ok = 1'b1;
            4'd1:    ok = lt | fl.z;
            4'd2:    ok = lt;
            4'd3:    ok = fl.z;
            4'd4:    ok = !fl.z;
            4'd5:    ok = !lt;
            4'd6:    ok = !lt && !fl.z;
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core import pipe5_pkg::*; #(
    parameter int AW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [AW-1:0]            imem_addr,
    input  logic [FETCH_BYTES*8-1:0] imem_bytes,
    input  logic [3:0]               rf_sel,
    output logic [XLEN-1:0]          rf_val,
    output logic [2:0]               status,
    output logic                     done
);
    pipe_t         st_q, st_d;
    logic [AW-1:0] pc_q, pc_d;
    logic          frozen;

    // fetch-side decode of the leading byte
    logic [3:0] f_op, f_fn, f_len;
    logic       f_ok;
    stat_e      f_stat;
    assign f_op = imem_bytes[7:4];
    assign f_fn = imem_bytes[3:0];

    always_comb begin
        f_len = 4'd1;
        f_ok  = 1'b0;
        case (f_op)
            OP_HALT, OP_NOP: f_ok = (f_fn == 4'd0);
            OP_MOV: begin f_ok = (f_fn <= 4'd6); f_len = 4'd2;  end
            OP_IMM: begin f_ok = (f_fn == 4'd0); f_len = 4'd10; end
            OP_ALU: begin f_ok = (f_fn <= 4'd3); f_len = 4'd2;  end
            default: f_ok = 1'b0;
        endcase
        if (!f_ok)                 f_stat = ST_INS;
        else if (f_op == OP_HALT)  f_stat = ST_HLT;
        else                       f_stat = ST_AOK;
    end

    // decode sources and destination
    logic    d_valid;
    reg_id_t d_src_a, d_src_b, d_dst;
    assign d_valid = (st_q.d.stat == ST_AOK);
    assign d_src_a = (d_valid && (st_q.d.op == OP_MOV || st_q.d.op == OP_ALU)) ? st_q.d.ra : RNONE;
    assign d_src_b = (d_valid && st_q.d.op == OP_ALU) ? st_q.d.rb : RNONE;
    assign d_dst   = (d_valid && (st_q.d.op == OP_MOV || st_q.d.op == OP_IMM ||
                                  st_q.d.op == OP_ALU)) ? st_q.d.rb : RNONE;

    // execute
    logic [3:0]      alu_fn;
    logic [XLEN-1:0] alu_a, alu_b, alu_res;
    flags_t          alu_fl;
    logic            e_cnd, e_ok, e_alu_upd, e_cmov_off;
    reg_id_t         e_dst;

    assign e_ok   = (st_q.e.stat == ST_AOK);
    assign alu_fn = (st_q.e.op == OP_ALU) ? st_q.e.fn : 4'd0;
    assign alu_a  = (st_q.e.op == OP_IMM) ? st_q.e.imm : st_q.e.va;
    assign alu_b  = (st_q.e.op == OP_ALU) ? st_q.e.vb : '0;

    pipe5_alu #(.W(XLEN)) alu_i (.fn(alu_fn), .a(alu_a), .b(alu_b), .res(alu_res), .fl(alu_fl));
    pipe5_cond cond_i (.fn(st_q.e.fn), .fl(st_q.cc), .ok(e_cnd));

    assign e_alu_upd  = e_ok && (st_q.e.op == OP_ALU);
    assign e_cmov_off = e_ok && (st_q.e.op == OP_MOV) && !e_cnd;
    assign e_dst      = e_cmov_off ? RNONE : st_q.e.dst;

    // register file, forwarding
    logic            rf_we;
    logic [XLEN-1:0] rf_a, rf_b, fwd_a, fwd_b;
    assign frozen = (st_q.w.stat != ST_AOK);
    assign rf_we  = !frozen && (st_q.w.dst != RNONE);

    pipe5_rf #(.W(XLEN), .N(NREG)) rf_i (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(st_q.w.dst), .wd(st_q.w.val),
        .ra_a(d_src_a), .ra_b(d_src_b), .ra_x(rf_sel),
        .rd_a(rf_a), .rd_b(rf_b), .rd_x(rf_val)
    );

    pipe5_fwd #(.W(XLEN)) fwd_a_i (
        .src(d_src_a), .e_dst(e_dst), .e_val(alu_res), .m_dst(st_q.m.dst), .m_val(st_q.m.val),
        .w_dst(st_q.w.dst), .w_val(st_q.w.val), .rf_val(rf_a), .val(fwd_a));
    pipe5_fwd #(.W(XLEN)) fwd_b_i (
        .src(d_src_b), .e_dst(e_dst), .e_val(alu_res), .m_dst(st_q.m.dst), .m_val(st_q.m.val),
        .w_dst(st_q.w.dst), .w_val(st_q.w.val), .rf_val(rf_b), .val(fwd_b));

    // next-state assembly
    always_comb begin
        st_d = st_q;
        pc_d = pc_q;
        if (!frozen) begin
            pc_d = (f_stat == ST_AOK) ? pc_q + AW'(f_len) : pc_q;
            st_d.d = '{stat: f_stat, op: f_op, fn: f_fn, ra: imem_bytes[15:12],
                       rb: imem_bytes[11:8], imm: imem_bytes[79:16]};
            st_d.e = '{stat: st_q.d.stat, op: st_q.d.op, fn: st_q.d.fn, va: fwd_a,
                       vb: fwd_b, imm: st_q.d.imm, dst: d_dst};
            st_d.m = '{stat: st_q.e.stat, cnd: e_cnd, val: alu_res, dst: e_dst};
            st_d.w = '{stat: st_q.m.stat, val: st_q.m.val, dst: st_q.m.dst};
            if (e_alu_upd) st_d.cc = alu_fl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PIPE_RESET;
            pc_q <= '0;
        end else begin
            st_q <= st_d;
            pc_q <= pc_d;
        end
    end

    assign imem_addr = pc_q;
    assign status    = st_q.w.stat;
    assign done      = frozen;
endmodule

// File: rtl/pipe5_core_chk.sv
`timescale 1ns/1ps
module pipe5_core_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [2:0]    status,
    input logic [AW-1:0] imem_addr,
    input logic [2:0]    d_stat,
    input logic [2:0]    cc,
    input logic          e_alu_upd,
    input logic          e_cmov_off,
    input logic [3:0]    m_dst,
    input logic          m_cnd
);
    // R3: a stopping instruction in decode means fetch holds its address
    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (d_stat != 3'd1) |=> $stable(imem_addr));

    // R4: status is always one legal code
    assert_status_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status) == 1);

    // R7: flags move only behind an ALU op in execute
    assert_cc_alu_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !e_alu_upd |=> $stable(cc));

    // R9: a failed conditional move reaches memory with no destination
    assert_cmov_null_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (e_cmov_off && !done) |=> (m_dst == 4'hF && !m_cnd));

    // R11: completion is sticky and status frozen
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(status) && $stable(imem_addr)));
endmodule

bind pipe5_core pipe5_core_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .done(done), .status(status), .imem_addr(imem_addr),
    .d_stat(st_q.d.stat), .cc(st_q.cc), .e_alu_upd(e_alu_upd), .e_cmov_off(e_cmov_off),
    .m_dst(st_q.m.dst), .m_cnd(st_q.m.cnd)
);

// File: tb/pipe5_core_tb_top.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
    localparam int AW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   imem_addr;
    logic [79:0]     imem_bytes;
    logic [3:0]      rf_sel = 4'd0;
    logic [63:0]     rf_val;
    logic [2:0]      status;
    logic            done;

    always #2 clk = ~clk;

    pipe5_core #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_bytes(imem_bytes),
        .rf_sel(rf_sel), .rf_val(rf_val), .status(status), .done(done));

    logic [7:0]  mem [256];
    logic [63:0] exp_reg [15];
    int          n_chk = 0, n_err = 0, wp = 0;
    int          edges, max_addr;
    int          trace [256];

    always_comb
        for (int k = 0; k < 10; k++) imem_bytes[8*k +: 8] = mem[8'(imem_addr[7:0] + 8'(k))];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wp = 0;
    endtask
    task automatic put(input logic [7:0] b);
        mem[wp] = b; wp++;
    endtask
    task automatic put_irm(input logic [3:0] rb, input logic [63:0] imm);
        put(8'h30); put({4'hF, rb});
        for (int k = 0; k < 8; k++) put(imm[8*k +: 8]);
    endtask
    task automatic put_rr(input logic [3:0] op, input logic [3:0] fn,
                          input logic [3:0] ra, input logic [3:0] rb);
        put({op, fn}); put({ra, rb});
    endtask

    function automatic bit cond_ok(input logic [3:0] fn, input logic z, s, o);
        case (fn)
            4'd0: return 1'b1;
            4'd1: return (s ^ o) | z;
            4'd2: return s ^ o;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return !(s ^ o);
            4'd6: return !(s ^ o) && !z;
            default: return 1'b0;
        endcase
    endfunction

    // sequential reference of the instruction set, built from R2..R10
    task automatic model(output int nf, output logic [2:0] st);
        int pc; logic z, s, o;
        logic [7:0] b0, b1; logic [3:0] op, fn, ra, rb; logic [63:0] a, bv, r, imm;
        for (int i = 0; i < 15; i++) exp_reg[i] = '0;
        z = 1'b1; s = 1'b0; o = 1'b0; pc = 0; nf = 0; st = 3'd1;
        while (nf < 100) begin
            b0 = mem[8'(pc)]; b1 = mem[8'(pc + 1)];
            op = b0[7:4]; fn = b0[3:0]; ra = b1[7:4]; rb = b1[3:0];
            nf++;
            if (b0 == 8'h00) begin st = 3'd2; break; end
            else if (b0 == 8'h10) pc += 1;
            else if (op == 4'h2 && fn <= 4'd6) begin
                if (cond_ok(fn, z, s, o) && rb != 4'hF) exp_reg[rb] = exp_reg[ra];
                pc += 2;
            end else if (b0 == 8'h30) begin
                for (int k = 0; k < 8; k++) imm[8*k +: 8] = mem[8'(pc + 2 + k)];
                if (rb != 4'hF) exp_reg[rb] = imm;
                pc += 10;
            end else if (op == 4'h6 && fn <= 4'd3) begin
                a = exp_reg[ra]; bv = exp_reg[rb];
                case (fn)
                    4'd0: begin r = bv + a; o = (a[63] == bv[63]) && (r[63] != a[63]); end
                    4'd1: begin r = bv - a; o = (a[63] != bv[63]) && (r[63] != bv[63]); end
                    4'd2: begin r = bv & a; o = 1'b0; end
                    default: begin r = bv ^ a; o = 1'b0; end
                endcase
                z = (r == '0); s = r[63];
                exp_reg[rb] = r;
                pc += 2;
            end else begin st = 3'd4; break; end
        end
    endtask

    task automatic read_reg(input int idx, output logic [63:0] v);
        @(negedge clk);
        rf_sel = 4'(idx);
        #1 v = rf_val;
    endtask

    task automatic run_prog(input string tag);
        int nf; logic [2:0] st; logic [63:0] v;
        model(nf, st);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        edges = 0; max_addr = 0; trace[0] = int'(imem_addr);
        while (!done && edges < 200) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
            trace[edges] = int'(imem_addr);
            if (int'(imem_addr) > max_addr) max_addr = int'(imem_addr);
        end
        chk({tag, " R3 R4 status"}, 64'(status), 64'(st));
        chk({tag, " R3 R5 cycle count"}, 64'(edges), 64'(nf + 3));
        for (int i = 0; i < 15; i++) begin
            read_reg(i, v);
            chk({tag, " R12 register"}, v, exp_reg[i]);
        end
    endtask

    task automatic random_prog();
        int n; logic [3:0] ra, rb; logic [63:0] imm;
        clear_mem();
        n = 6 + int'($urandom % 10);
        for (int i = 0; i < n; i++) begin
            ra = ($urandom % 4 != 0) ? 4'($urandom % 4) : 4'($urandom % 15);
            rb = ($urandom % 4 != 0) ? 4'($urandom % 4) : 4'($urandom % 15);
            case ($urandom % 4)
                0: begin
                    case ($urandom % 3)
                        0: imm = 64'($urandom % 8);
                        1: imm = {$urandom, $urandom};
                        default: imm = {1'b0, 63'h7FFF_FFFF_FFFF_FFF0} + 64'($urandom % 32);
                    endcase
                    if ($urandom % 10 == 0) rb = 4'hF;
                    put_irm(rb, imm);
                end
                1: put_rr(4'h2, 4'($urandom % 7), ra, rb);
                default: put_rr(4'h6, 4'($urandom % 4), ra, rb);
            endcase
        end
        if ($urandom % 5 == 0) put(8'hB0);
        else put(8'h00);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] v, v2;
        logic [2:0]  st_hold;
        void'($urandom(32'd2024));
        clear_mem();

        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 status in reset", 64'(status), 64'd1);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 fetch address in reset", 64'(imem_addr), 64'd0);
        rf_sel = 4'd3;
        #1 chk("R1 register in reset", rf_val, 64'd0);

        // halt only: 4 edges, address 0 throughout (R3)
        clear_mem(); put(8'h00);
        run_prog("halt-only");
        chk("R3 halt edges", 64'(edges), 64'd4);
        chk("R3 halt never leaves 0", 64'(max_addr), 64'd0);

        // three no-ops then halt, trailing no-op never fetched (R3)
        clear_mem(); put(8'h10); put(8'h10); put(8'h10); put(8'h00); put(8'h10);
        run_prog("nop-halt");
        chk("R3 nop-halt max address", 64'(max_addr), 64'd3);
        chk("R3 nop-halt edges", 64'(edges), 64'd7);

        // invalid byte after a no-op (R4)
        clear_mem(); put(8'h10); put(8'hC0); put(8'hF8); put_irm(4'd0, 64'd1);
        run_prog("invalid-op");
        chk("R4 invalid status code", 64'(status), 64'd4);
        chk("R4 invalid edges", 64'(edges), 64'd5);

        // move with fn 7 is invalid and must not write (R4)
        clear_mem(); put_irm(4'd0, 64'd9); put_rr(4'h2, 4'd7, 4'd0, 4'd1);
        run_prog("bad-move-fn");
        read_reg(1, v);
        chk("R4 bad move left rcx", v, 64'd0);

        // immediate then dependent move; fetch lengths (R2, R5)
        clear_mem(); put_irm(4'd0, 64'd1); put_rr(4'h2, 4'd0, 4'd0, 4'd3);
        run_prog("imm-move");
        chk("R2 address after first fetch", 64'(trace[1]), 64'd10);
        chk("R2 address after second fetch", 64'(trace[2]), 64'd12);
        chk("R3 imm-move edges", 64'(edges), 64'd6);
        read_reg(3, v);
        chk("R5 forwarded move", v, 64'd1);
        // R11: frozen after done
        st_hold = status;
        repeat (4) @(negedge clk);
        chk("R11 status held", 64'(status), 64'(st_hold));
        chk("R11 address held", 64'(imem_addr), 64'(trace[edges]));
        read_reg(0, v2);
        chk("R11 register held", v2, 64'd1);
        read_reg(15, v2);
        chk("R12 code 15 reads zero", v2, 64'd0);

        // ALU chain (R6, R5)
        clear_mem();
        put_irm(4'd2, 64'd7); put_irm(4'd1, 64'd3);
        put_rr(4'h6, 4'd0, 4'd1, 4'd3); put_rr(4'h6, 4'd1, 4'd2, 4'd1);
        put_rr(4'h6, 4'd2, 4'd2, 4'd3); put_rr(4'h6, 4'd3, 4'd1, 4'd2);
        put_rr(4'h6, 4'd2, 4'd2, 4'd6);
        run_prog("alu-chain");
        read_reg(1, v);
        chk("R6 sub result", v, 64'hFFFF_FFFF_FFFF_FFFC);
        read_reg(2, v);
        chk("R6 xor result", v, 64'hFFFF_FFFF_FFFF_FFFB);

        // conditional moves over three flag settings (R7, R8, R9)
        clear_mem();
        put_irm(4'd3, 64'h0ACE); put_irm(4'd0, 64'd1); put_rr(4'h6, 4'd2, 4'd0, 4'd0);
        put_rr(4'h2, 4'd6, 4'd3, 4'd1); put_rr(4'h2, 4'd4, 4'd3, 4'd2);
        put_irm(4'd0, 64'hFFFF_FFFF_FFFF_FFFF); put_rr(4'h6, 4'd2, 4'd0, 4'd0);
        put_rr(4'h2, 4'd2, 4'd3, 4'd4); put_rr(4'h2, 4'd1, 4'd3, 4'd5);
        put_rr(4'h6, 4'd3, 4'd0, 4'd0);
        put_rr(4'h2, 4'd3, 4'd3, 4'd6); put_rr(4'h2, 4'd5, 4'd3, 4'd7);
        put_irm(4'd3, 64'h0BAD);
        put_rr(4'h2, 4'd2, 4'd3, 4'd1); put_rr(4'h2, 4'd4, 4'd3, 4'd6);
        put_rr(4'h2, 4'd6, 4'd3, 4'd8); put_rr(4'h6, 4'd0, 4'd8, 4'd9);
        run_prog("cmov-set");
        read_reg(1, v);
        chk("R8 R9 false cmov kept value", v, 64'h0ACE);
        read_reg(9, v);
        chk("R9 no forward from false cmov", v, 64'd0);

        // signed overflow feeding conditions (R7)
        clear_mem();
        put_irm(4'd0, 64'h7FFF_FFFF_FFFF_FFFF); put_irm(4'd1, 64'd1); put_irm(4'd5, 64'd55);
        put_rr(4'h6, 4'd0, 4'd0, 4'd1);
        put_rr(4'h2, 4'd2, 4'd5, 4'd6); put_rr(4'h2, 4'd5, 4'd5, 4'd7);
        run_prog("overflow");
        read_reg(7, v);
        chk("R7 overflow makes ge true", v, 64'd55);
        read_reg(6, v);
        chk("R7 overflow makes l false", v, 64'd0);

        // destination code 15 (R10)
        clear_mem(); put_irm(4'hF, 64'd5); put_irm(4'd0, 64'd9);
        put_rr(4'h6, 4'd0, 4'd0, 4'd0);
        run_prog("none-dest");
        read_reg(0, v);
        chk("R10 none destination ignored", v, 64'd18);

        // random programs
        for (int p = 0; p < 40; p++) begin
            random_prog();
            run_prog("random R5 R6 R7 R8 R9 R10");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule